// File: doc/BRIEF.md
# DMA Request-Line Router

This block sits between the hardware request lines of a chip's peripherals and the request inputs of a DMA engine's channels. Each request line has a 32-bit routing entry, written and read by software over a simple register bus. The entry names the channel that the line drives. Every clock cycle the router combines, for each channel, the lines that are routed to it and the channel's one-shot software trigger. It then gates the result with the channel's enable bit and registers it onto a per-channel request output.

Request lines are numbered from 1. Input bit `line_req[k]` carries line k+1. The number 0 is kept for software-started transfers and has no routing entry. An entry holds the channel index plus one, so a zero entry leaves the line disconnected. Software fills in the entry when it starts a channel and writes zero back when it stops it. Several lines may share one channel.

Top module: `dma_reqline_mapper`

## Requirements
- R1: After reset, every routing entry and every channel enable is 0, `chan_req` is all zeros and `reg_rdata` is 0.
- R2: The entry for line u (1..NUM_LINES) is at byte address 0x2000 + 4*(u-1). It holds all 32 written bits and returns them on `reg_rdata` one cycle after a read strobe. `reg_rdata` is 0 in any cycle that follows a cycle without a read.
- R3: An entry value k with 1 <= k <= NUM_CH routes its line to channel k-1. `chan_req` reflects the `line_req` value sampled at the previous rising edge, under the entries and enables in force at that edge.
- R4: An entry value of 0 leaves its line connected to no channel, including after a previously valid entry is cleared.
- R5: An entry value greater than NUM_CH is treated as 0. It still reads back unchanged.
- R6: When several lines are routed to one channel, that channel's request is the OR of those lines.
- R7: The control word of channel c is at 0x1000 + 4*c, and bit 0 of that word is the channel enable. The enable reads back in bit 0. A channel whose enable is 0 drives no request, either from its lines or from its software trigger.
- R8: Writing 1 to bit 1 of a control word raises that channel's request for exactly one cycle, two rising edges after the write is sampled. Bit 1 always reads back as 0.
- R9: A software trigger and a hardware line request that reach the same channel at the same edge merge into one request. A trigger on one channel and a line request on another, at the same edge, both appear in the same cycle.
- R10: Writes to addresses outside the two windows have no effect on routing or on stored state, and reads of such addresses return 0. This covers the slot where a line 0 entry would sit (0x1FFC), the word past the last entry and the word past the last control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (16) | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| line_req | input | NUM_LINES (16) | Peripheral request lines; bit k is line k+1 |
| chan_req | output | NUM_CH (8) | Registered request per DMA channel |

## Verification
The software trigger and a hardware line can reach the same channel register in one cycle. This is the collision that matters. The bench writes a trigger and, in the following cycle, raises a line routed to the same channel, so both are sampled at the same edge. It expects one merged request in that cycle, and the line alone keeps the request up in the cycle after. A second case points the trigger and a line at two different channels at the same edge and expects both bits together.

// File: rtl/mapper_pkg.sv
`timescale 1ns/1ps
package mapper_pkg;
  // Byte base addresses of the two register windows.
  localparam logic [31:0] MAP_BASE = 32'h0000_2000;
  localparam logic [31:0] CTL_BASE = 32'h0000_1000;
  // Field positions inside a channel control word.
  localparam int unsigned CTL_EN_BIT = 0;
  localparam int unsigned CTL_SW_BIT = 1;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_MAP,
    WIN_CTL
  } win_e;
endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/map_regfile.sv
`timescale 1ns/1ps
module map_regfile
  import mapper_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] entry_o [NUM_LINES],
  output logic [NUM_CH-1:0] ch_en_o,
  output logic [NUM_CH-1:0] sw_pulse_o
);
  localparam int unsigned LIW     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int unsigned CIW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [31:0] MAP_END = MAP_BASE + 32'(4 * NUM_LINES);
  localparam logic [31:0] CTL_END = CTL_BASE + 32'(4 * NUM_CH);

  logic [31:0]       a32;
  win_e              win;
  logic [LIW-1:0]    map_idx;
  logic [CIW-1:0]    ctl_idx;
  logic [NUM_LINES-1:0] ent_we;
  logic              ctl_we;
  logic [NUM_CH-1:0] en_q, en_d;
  logic [NUM_CH-1:0] sw_q, sw_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // Address decode
  assign a32 = 32'(reg_addr);

  always_comb begin
    if (a32 >= MAP_BASE && a32 < MAP_END)      win = WIN_MAP;
    else if (a32 >= CTL_BASE && a32 < CTL_END) win = WIN_CTL;
    else                                       win = WIN_NONE;
  end

  assign map_idx = LIW'((a32 - MAP_BASE) >> 2);
  assign ctl_idx = CIW'((a32 - CTL_BASE) >> 2);
  assign ctl_we  = reg_wr && (win == WIN_CTL);

  // Routing entries, one clock-enabled word per line
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    assign ent_we[l] = reg_wr && (win == WIN_MAP) && (map_idx == LIW'(l));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ent_q <= '0;
      else if (ent_we[l])  ent_q <= reg_wdata;
    end
    assign entry_o[l] = ent_q;
  end

  // Channel control next state
  always_comb begin
    en_d = en_q;
    sw_d = '0;
    if (ctl_we) begin
      en_d[ctl_idx] = reg_wdata[CTL_EN_BIT];
      sw_d[ctl_idx] = reg_wdata[CTL_SW_BIT];
    end
  end

  // Read data next state
  always_comb begin
    rdata_d = '0;
    if (reg_rd) begin
      unique case (win)
        WIN_MAP: rdata_d = entry_o[map_idx];
        WIN_CTL: rdata_d[CTL_EN_BIT] = en_q[ctl_idx];
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (ctl_we) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q    <= '0;
      rdata_q <= '0;
    end else begin
      sw_q    <= sw_d;
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata  = rdata_q;
  assign ch_en_o    = en_q;
  assign sw_pulse_o = sw_q;

  // Assertions
  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0))
    else $error("read data not zero after idle cycle");

  assert_sw_bit_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (win == WIN_CTL)) |=> (reg_rdata[CTL_SW_BIT] == 1'b0))
    else $error("software trigger bit read back as 1");

  assert_pulse_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (sw_pulse_o == '0))
    else $error("software pulse without a register write");
endmodule

// File: rtl/map_router.sv
`timescale 1ns/1ps
module map_router #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_req,
  input  logic [DATA_W-1:0]    entry_i [NUM_LINES],
  input  logic [NUM_CH-1:0]    ch_en_i,
  input  logic [NUM_CH-1:0]    sw_pulse_i,
  output logic [NUM_CH-1:0]    chan_req
);
  logic [NUM_LINES-1:0] hit [NUM_CH];
  logic [NUM_CH-1:0]    req_d, req_q;

  // Line-to-channel match matrix; values outside 1..NUM_CH match nothing
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_ln
      assign hit[c][l] = (entry_i[l] == DATA_W'(c + 1));
    end
    assign req_d[c] = ch_en_i[c] & ((|(hit[c] & line_req)) | sw_pulse_i[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign chan_req = req_q;

  // Assertions
  logic any_map;
  always_comb begin
    any_map = 1'b0;
    for (int l = 0; l < NUM_LINES; l++) any_map = any_map | (entry_i[l] != '0);
  end

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en_i != '1) |=> ((chan_req & ~$past(ch_en_i)) == '0))
    else $error("disabled channel raised a request");

  assert_unmapped_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_map && (sw_pulse_i == '0)) |=> (chan_req == '0))
    else $error("request with every entry clear and no trigger");
endmodule

// File: rtl/dma_reqline_mapper.sv
`timescale 1ns/1ps
module dma_reqline_mapper #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_CH    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] line_req,
  output logic [NUM_CH-1:0]    chan_req
);
  localparam int unsigned DATA_W = 32;

  logic              rst_n_s;
  logic [DATA_W-1:0] entry [NUM_LINES];
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] sw_pulse;

  rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  map_regfile #(
    .NUM_LINES (NUM_LINES),
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .entry_o    (entry),
    .ch_en_o    (ch_en),
    .sw_pulse_o (sw_pulse)
  );

  map_router #(
    .NUM_LINES (NUM_LINES),
    .NUM_CH    (NUM_CH),
    .DATA_W    (DATA_W)
  ) u_route (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .line_req   (line_req),
    .entry_i    (entry),
    .ch_en_i    (ch_en),
    .sw_pulse_i (sw_pulse),
    .chan_req   (chan_req)
  );
endmodule

// File: tb/tb_dma_reqline_mapper.sv
`timescale 1ns/1ps
module tb_dma_reqline_mapper;
  localparam int NL = 16;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd;
  logic [15:0]   reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [NL-1:0] line_req;
  logic [NC-1:0] chan_req;

  dma_reqline_mapper #(.NUM_LINES(NL), .NUM_CH(NC), .ADDR_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_req(line_req), .chan_req(chan_req)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  // Requirement-level model of stored state
  logic [31:0]   m_entry [NL];
  logic [NC-1:0] m_en;

  function automatic logic [NC-1:0] route(input logic [NL-1:0] v, input logic [NC-1:0] sw);
    logic [NC-1:0] r;
    r = '0;
    for (int l = 0; l < NL; l++)
      if (v[l] && m_entry[l] != 0 && m_entry[l] <= NC) r[m_entry[l] - 1] = 1'b1;
    return (r | sw) & m_en;
  endfunction

  function automatic logic [15:0] mapa(input int u);
    return 16'(32'h2000 + 4 * (u - 1));
  endfunction

  function automatic logic [15:0] ctla(input int c);
    return 16'(32'h1000 + 4 * c);
  endfunction

  task automatic push(input bit is_rd, input logic [31:0] exp, input string tag);
    item_t it;
    it.due = cyc + 1; it.is_rd = is_rd; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    int ai;
    tick();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    ai = int'(a);
    if (ai >= 'h2000 && ai < 'h2000 + 4 * NL) m_entry[(ai - 'h2000) / 4] = d;
    if (ai >= 'h1000 && ai < 'h1000 + 4 * NC) m_en[(ai - 'h1000) / 4] = d[0];
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    tick();
    reg_rd = 1'b1; reg_addr = a;
    push(1'b1, exp, tag);
  endtask

  task automatic lines(input logic [NL-1:0] v, input logic [NC-1:0] sw, input string tag);
    tick();
    line_req = v;
    push(1'b0, 32'(route(v, sw)), tag);
  endtask

  // Monitor: pops scheduled expectations and compares
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = it.is_rd ? reg_rdata : 32'(chan_req);
      n_cmp++;
      if (it.due != cyc || act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: %s actual=%h expected=%h (due %0d at %0d)",
                 it.tag, it.is_rd ? "reg_rdata" : "chan_req", act, it.exp, it.due, cyc);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < NL; l++) m_entry[l] = '0;
    m_en = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0; line_req = '0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    lines('0, '0, "R1");
    rd_chk(mapa(1), 32'h0, "R1");
    rd_chk(ctla(0), 32'h0, "R1");

    // Enable all channels, program entries
    for (int c = 0; c < NC; c++) wr(ctla(c), 32'h1);
    wr(mapa(3), 32'd2);
    wr(mapa(16), 32'hDEAD_BEEF);
    wr(mapa(4), 32'(NC + 1));
    wr(mapa(6), 32'(NC));
    rd_chk(mapa(3), 32'd2, "R2");
    rd_chk(mapa(16), 32'hDEAD_BEEF, "R2");
    rd_chk(ctla(1), 32'h1, "R7");

    // R3: routing, including the highest channel
    lines(NL'(1) << 2, '0, "R3");
    lines(NL'(1) << 5, '0, "R3");
    // R5: out-of-range entries drive nothing
    lines(NL'(1) << 15, '0, "R5");
    lines(NL'(1) << 3, '0, "R5");
    rd_chk(mapa(4), 32'(NC + 1), "R5");

    // R6: several lines to one channel
    wr(mapa(5), 32'd2);
    lines(NL'(1) << 4, '0, "R6");
    lines((NL'(1) << 2) | (NL'(1) << 4), '0, "R6");
    lines((NL'(1) << 2) | (NL'(1) << 4) | (NL'(1) << 5), '0, "R6");

    // R7: disabled channel stays quiet
    wr(ctla(1), 32'h0);
    lines(NL'(1) << 2, '0, "R7");
    lines('0, '0, "R7");
    wr(ctla(1), 32'h1);

    // R8: software trigger pulse, one cycle
    wr(ctla(0), 32'h3);
    lines('0, NC'(1), "R8");
    lines('0, '0, "R8");
    rd_chk(ctla(0), 32'h1, "R8");
    // R7: trigger on a channel being disabled by the same write
    wr(ctla(2), 32'h2);
    lines('0, NC'(4), "R7");
    wr(ctla(2), 32'h1);

    // R9: trigger and line on the same channel at the same edge
    wr(mapa(1), 32'd1);
    wr(ctla(0), 32'h3);
    lines(NL'(1), NC'(1), "R9");
    lines(NL'(1), '0, "R9");
    lines('0, '0, "R9");
    // R9: trigger and line on different channels at the same edge
    wr(ctla(0), 32'h3);
    lines(NL'(1) << 2, NC'(1), "R9");
    lines('0, '0, "R9");

    // R4: clearing an entry disconnects the line
    wr(mapa(3), 32'h0);
    lines(NL'(1) << 2, '0, "R4");
    rd_chk(mapa(3), 32'h0, "R4");

    // R10: addresses outside the windows
    wr(16'h1FFC, 32'h1);
    wr(ctla(NC), 32'h3);
    wr(mapa(NL + 1), 32'h2);
    wr(16'h0000, 32'h5);
    lines('0, '0, "R10");
    rd_chk(16'h1FFC, 32'h0, "R10");
    rd_chk(ctla(NC), 32'h0, "R10");
    rd_chk(mapa(NL + 1), 32'h0, "R10");
    rd_chk(mapa(1), 32'h1, "R10");
    lines('1, '0, "R10");
    lines('0, '0, "R10");

    repeat (4) tick();
    if (sbq.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sbq.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule